// File: doc/BRIEF.md
# Vector Register Element Move Unit

This block carries 16-bit values between a 32-bit scalar operand and a file of wide vector registers, and between that scalar operand and a small bank of 16-bit vector control registers. Each vector register is 128 bits wide and is addressed as 16 byte elements. An element index selects where a 16-bit pair starts inside the selected vector register.

Four operations are offered: a pair write into a vector register, a sign-extended pair read out of a vector register, a control-register write and a sign-extended control-register read. Writes are registered and take effect on the clock edge at which `op_valid` is high. Reads are combinational from the current contents and do not depend on `op_valid`. The last element index is treated asymmetrically. A write there touches only the final byte. A read there wraps around and takes its low byte from element 0.

Top module: `vmove_unit`

## Requirements
- R1: A synchronous active-high reset clears every vector register byte and every control register to zero, so every read afterwards returns 0.
- R2: A vector write (`op_sel` = 2'b00, `op_valid` high) with element index e below 15 puts scalar bits 15..8 into byte e and bits 7..0 into byte e+1 of register `reg_idx`, with no other byte changing. Byte k occupies bits 8k+7..8k. The new values are readable in the cycle after the edge.
- R3: A vector write with element index 15 puts scalar bits 15..8 into byte 15 only. Byte 0 and all other bytes keep their values.
- R4: A vector read (`op_sel` = 2'b01) returns {byte e, byte e+1} of register `reg_idx`, sign-extended from 16 to 32 bits, combinationally.
- R5: A vector read with element index 15 returns {byte 15, byte 0} of the same register, sign-extended.
- R6: A control write (`op_sel` = 2'b10, `op_valid` high) with `reg_idx` 0, 1 or 2 stores scalar bits 15..0 into that control register.
- R7: A control read (`op_sel` = 2'b11) returns the control register selected by `reg_idx`, sign-extended from 16 to 32 bits.
- R8: Control writes and control reads give the same result for every value of the element index.
- R9: A control register index of 3 or above reads as zero, and a write to such an index changes no control register.
- R10: No register changes when `op_valid` is low, or when the operation is a read. The scalar result is 0 while a write operation is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Applies the selected write operation on this edge |
| op_sel | input | 2 | 00 vector write, 01 vector read, 10 control write, 11 control read |
| elem | input | 4 | Byte element index within the vector register |
| reg_idx | input | 5 | Vector register number, or control register number |
| scalar_in | input | 32 | Scalar operand; only bits 15..0 are used |
| scalar_out | output | 32 | Sign-extended read result |

## Verification
The hardest case to reach from the ports is a write at element 15 next to a non-zero byte 0. A read at element 15 would show a stray write to byte 0 only if byte 0 already held a known value. The sweep therefore fills every element of a register in ascending order, so that byte 0 is loaded before the element-15 write. After each write it reads all sixteen elements back, so any clobbered byte, including the wrapped low byte, shows up as a mismatch against the bench's byte model.

// File: rtl/vmove_pkg.sv
package vmove_pkg;
    localparam int VREG_COUNT = 32;
    localparam int VREG_BYTES = 16;
    localparam int SCALAR_W   = 32;
    localparam int CTRL_COUNT = 3;
    localparam int CTRL_W     = 16;
    localparam int PAIR_W     = 16;

    typedef enum logic [1:0] {
        OP_TO_VEC    = 2'b00,
        OP_FROM_VEC  = 2'b01,
        OP_TO_CTRL   = 2'b10,
        OP_FROM_CTRL = 2'b11
    } move_op_e;
endpackage

// File: rtl/vmove_byte_plan.sv
module vmove_byte_plan #(
    parameter int BYTES = vmove_pkg::VREG_BYTES,
    localparam int EW   = $clog2(BYTES)
) (
    input  logic [EW-1:0]      elem,
    input  logic [15:0]        half,
    output logic [BYTES-1:0]   byte_en,
    output logic [BYTES*8-1:0] byte_data
);
    localparam logic [EW-1:0] LAST = EW'(BYTES - 1);

    logic [EW-1:0] elem_next;
    assign elem_next = elem + EW'(1);

    for (genvar k = 0; k < BYTES; k++) begin : g_lane
        logic is_hi;
        logic is_lo;
        assign is_hi = (EW'(k) == elem);
        // the low half is dropped at the last element instead of wrapping
        assign is_lo = (EW'(k) == elem_next) && (elem != LAST);
        assign byte_en[k] = is_hi | is_lo;
        assign byte_data[k*8 +: 8] = is_hi ? half[15:8] : half[7:0];
    end

    always_comb begin
        assert_lane_count_R3: assert ($countones(byte_en) == ((elem == LAST) ? 1 : 2));
    end
endmodule

// File: rtl/vmove_pair_fetch.sv
module vmove_pair_fetch #(
    parameter int BYTES = vmove_pkg::VREG_BYTES,
    localparam int EW   = $clog2(BYTES)
) (
    input  logic [BYTES*8-1:0] vreg,
    input  logic [EW-1:0]      elem,
    output logic [15:0]        pair
);
    logic [EW-1:0] lo_idx;
    // modular increment: the last element pairs with element 0
    assign lo_idx = elem + EW'(1);
    assign pair   = {vreg[{elem, 3'b000} +: 8], vreg[{lo_idx, 3'b000} +: 8]};
endmodule

// File: rtl/vmove_ctrl_file.sv
module vmove_ctrl_file #(
    parameter int COUNT = vmove_pkg::CTRL_COUNT,
    parameter int WIDTH = vmove_pkg::CTRL_W,
    parameter int IW    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IW-1:0]    idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    typedef struct packed {
        logic [COUNT-1:0][WIDTH-1:0] regs;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        in_range;

    assign in_range = (int'(idx) < COUNT);

    always_comb begin
        st_d  = st_q;
        rdata = '0;
        for (int i = 0; i < COUNT; i++) begin
            if (in_range && int'(idx) == i) begin
                rdata = st_q.regs[i];
                if (wr_en) st_d.regs[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assert_oor_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !in_range) |=> $stable(st_q));
    assert_oor_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !in_range |-> (rdata == '0));
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(st_q));
endmodule

// File: rtl/vmove_unit.sv
module vmove_unit
    import vmove_pkg::*;
#(
    parameter int NREG   = VREG_COUNT,
    parameter int NBYTES = VREG_BYTES,
    parameter int SW     = SCALAR_W,
    parameter int NCTRL  = CTRL_COUNT,
    parameter int CW     = CTRL_W,
    localparam int BW    = NBYTES * 8,
    localparam int EW    = $clog2(NBYTES),
    localparam int RW    = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [1:0]    op_sel,
    input  logic [EW-1:0] elem,
    input  logic [RW-1:0] reg_idx,
    input  logic [SW-1:0] scalar_in,
    output logic [SW-1:0] scalar_out
);
    typedef struct packed {
        logic [NREG-1:0][BW-1:0] vreg;
    } vec_state_t;

    vec_state_t     st_d, st_q;
    move_op_e       op;
    logic [NBYTES-1:0] lane_en;
    logic [BW-1:0]  lane_data;
    logic [15:0]    pair;
    logic [CW-1:0]  ctrl_rd;
    logic           ctrl_we;

    assign op      = move_op_e'(op_sel);
    assign ctrl_we = op_valid && (op == OP_TO_CTRL);

    vmove_byte_plan #(.BYTES(NBYTES)) u_plan (
        .elem      (elem),
        .half      (scalar_in[15:0]),
        .byte_en   (lane_en),
        .byte_data (lane_data)
    );

    vmove_pair_fetch #(.BYTES(NBYTES)) u_fetch (
        .vreg (st_q.vreg[reg_idx]),
        .elem (elem),
        .pair (pair)
    );

    vmove_ctrl_file #(.COUNT(NCTRL), .WIDTH(CW), .IW(RW)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (ctrl_we),
        .idx   (reg_idx),
        .wdata (scalar_in[CW-1:0]),
        .rdata (ctrl_rd)
    );

    always_comb begin
        st_d = st_q;
        if (op_valid && op == OP_TO_VEC) begin
            for (int k = 0; k < NBYTES; k++) begin
                if (lane_en[k]) st_d.vreg[reg_idx][k*8 +: 8] = lane_data[k*8 +: 8];
            end
        end
    end

    always_comb begin
        unique case (op)
            OP_FROM_VEC:  scalar_out = {{(SW-16){pair[15]}}, pair};
            OP_FROM_CTRL: scalar_out = {{(SW-CW){ctrl_rd[CW-1]}}, ctrl_rd};
            default:      scalar_out = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_q == '0));
    assert_last_elem_keeps_byte0_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_TO_VEC && elem == EW'(NBYTES-1))
        |=> (st_q.vreg[$past(reg_idx)][7:0] == $past(st_q.vreg[reg_idx][7:0])));
    assert_read_sign_ext_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_FROM_VEC) |-> (scalar_out[SW-1:16] == {(SW-16){scalar_out[15]}}));
    assert_ctrl_sign_ext_R7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_FROM_CTRL) |-> (scalar_out[SW-1:CW] == {(SW-CW){scalar_out[CW-1]}}));
    assert_no_vec_write_R10: assert property (@(posedge clk) disable iff (rst)
        !(op_valid && op == OP_TO_VEC) |=> $stable(st_q));
    assert_write_result_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (op == OP_TO_VEC || op == OP_TO_CTRL) |-> (scalar_out == '0));
endmodule

// File: tb/vmove_unit_test.sv
module vmove_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [1:0]  op_sel;
    logic [3:0]  elem;
    logic [4:0]  reg_idx;
    logic [31:0] scalar_in;
    logic [31:0] scalar_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0]  mdl [32][16];
    logic [15:0] cmdl [3];

    vmove_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .elem(elem), .reg_idx(reg_idx), .scalar_in(scalar_in), .scalar_out(scalar_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sx16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic do_write(input logic [1:0] op, input int e, input int r, input logic [31:0] d,
                            input logic v = 1'b1);
        @(negedge clk);
        op_sel = op; elem = 4'(e); reg_idx = 5'(r); scalar_in = d; op_valid = v;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic read_vec(input string tag, input int r, input int e);
        op_sel = 2'b01; elem = 4'(e); reg_idx = 5'(r); op_valid = 1'b0;
        #1;
        check(tag, scalar_out, sx16({mdl[r][e], mdl[r][(e+1)%16]}));
    endtask

    task automatic read_ctrl(input string tag, input int r, input int e);
        op_sel = 2'b11; elem = 4'(e); reg_idx = 5'(r); op_valid = 1'b0;
        #1;
        check(tag, scalar_out, (r < 3) ? sx16(cmdl[r]) : 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 4000; i++) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int regs [3] = '{0, 7, 31};
        for (int r = 0; r < 32; r++) for (int e = 0; e < 16; e++) mdl[r][e] = 8'h00;
        for (int i = 0; i < 3; i++) cmdl[i] = 16'h0;
        rst = 1'b1; op_valid = 1'b0; op_sel = 2'b00; elem = 4'd0; reg_idx = 5'd0; scalar_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int e = 0; e < 16; e++) read_vec("R1 vec reset", 31, e);
        for (int c = 0; c < 3; c++) read_ctrl("R1 ctrl reset", c, 0);

        // R2/R3/R4/R5: full element sweep, ascending, readback of every element
        foreach (regs[ri]) begin
            int r = regs[ri];
            for (int e = 0; e < 16; e++) begin
                logic [15:0] h = 16'(r * 16'h0913 + e * 16'h2B07 + 16'h8001);
                do_write(2'b00, e, r, {16'hDEAD, h});
                mdl[r][e] = h[15:8];
                if (e < 15) mdl[r][e+1] = h[7:0];
                for (int q = 0; q < 16; q++)
                    read_vec((e == 15) ? "R3 last-elem write" :
                             (q == 15) ? "R5 wrap read" : "R2 R4 pair write/read", r, q);
            end
        end

        // R3: element-15 write with byte 0 preset to a distinct value
        do_write(2'b00, 0, 5, 32'h0000_C3A1); mdl[5][0] = 8'hC3; mdl[5][1] = 8'hA1;
        do_write(2'b00, 15, 5, 32'h0000_7E55); mdl[5][15] = 8'h7E;
        read_vec("R3 byte0 kept", 5, 0);
        read_vec("R5 wrap uses byte0", 5, 15);
        read_vec("R3 byte14 kept", 5, 14);

        // R10: writes with op_valid low and reads with op_valid high change nothing
        do_write(2'b00, 3, 5, 32'h0000_1234, 1'b0);
        read_vec("R10 idle vec write", 5, 2);
        read_vec("R10 idle vec write", 5, 3);
        do_write(2'b01, 3, 5, 32'h0000_5678);
        read_vec("R10 read does not write", 5, 3);
        op_sel = 2'b00; #1; check("R10 write result zero", scalar_out, 32'h0);
        op_sel = 2'b10; #1; check("R10 ctrl write result zero", scalar_out, 32'h0);

        // R6/R7/R8: control writes with varied element index, reads with varied index
        for (int c = 0; c < 3; c++) begin
            logic [15:0] v = 16'(16'h8F01 + c * 16'h3131);
            do_write(2'b10, c * 5 + 1, c, {16'hBEEF, v});
            cmdl[c] = v;
            for (int e = 0; e < 16; e++) read_ctrl("R6 R7 R8 ctrl rw", c, e);
        end
        do_write(2'b10, 0, 1, 32'h0000_0042); cmdl[1] = 16'h0042;
        read_ctrl("R7 positive ctrl", 1, 9);

        // R9: out-of-range control index
        for (int c = 3; c < 32; c += 7) begin
            do_write(2'b10, 2, c, 32'h0000_FFFF);
            for (int k = 0; k < 3; k++) read_ctrl("R9 oor write ignored", k, 4);
            read_ctrl("R9 oor reads zero", c, 4);
        end
        do_write(2'b10, 0, 2, 32'h0000_1111, 1'b0);
        read_ctrl("R10 idle ctrl write", 2, 0);

        // R1: reset again after activity
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int r = 0; r < 32; r++) for (int e = 0; e < 16; e++) mdl[r][e] = 8'h00;
        for (int i = 0; i < 3; i++) cmdl[i] = 16'h0;
        read_vec("R1 vec cleared", 7, 4);
        read_vec("R1 vec cleared", 5, 15);
        read_ctrl("R1 ctrl cleared", 0, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule